// File: doc/BRIEF.md
# Four-Channel DMA Address and Count Engine

This block holds the transfer state for four DMA channels and turns device requests into bus cycles. Software programs it one byte at a time through a single write port. Each channel has:
- a 16-bit current address, loaded as two bytes through a shared byte pointer;
- a 16-bit count, loaded the same way;
- an 8-bit page value that supplies the upper address bits;
- a mode setting that picks the transfer direction and either single or cascade operation;
- a mask bit.

When an unmasked channel in single mode raises its request, the engine grants it with a one-cycle acknowledge. In the same cycle it drives the 24-bit bus address. It then steps the address up and the count down. When the count passes below zero, the engine signals terminal count and masks the channel. A cascade channel's acknowledge simply follows its request, so an external master can own the bus. The parameter `WORD_MODE` chooses between byte addressing and 16-bit-word addressing.

Top module: `dma4_engine`

## Requirements
- R1: After reset, all four channels are masked, the byte pointer selects the low byte, and `dack`, `addr_valid` and `tc` are low. A request on any channel then produces no acknowledge.
- R2: A write to offset 2c loads the address register of channel c, and a write to offset 2c+1 loads its count register. One byte pointer serves all these registers: the low byte is loaded first, and each access toggles the pointer.
- R3: A write of any value to offset 12 returns the byte pointer to the low byte.
- R4: A write to offset 11 sets the mode of the channel named in bits [1:0]. Bit 2 set makes `mem_wr` high during that channel's transfers. Bits [7:6] = 11 select cascade, and any other value selects single.
- R5: A write to offset 10 masks the channel named in bits [1:0] when bit 2 is 1, and unmasks it when bit 2 is 0. A masked channel's request is ignored.
- R6: A programmed count of N-1 gives exactly N transfers. On the last transfer, `tc` is high together with `dack`, and the channel masks itself.
- R7: Fixed priority applies, with channel 0 highest, and at most one `dack` bit is high at any time.
- R8: A request sampled at a clock edge gives `dack`, `addr_valid` and `addr_out` for exactly the next cycle. The cycle after a single transfer grants nothing. Each transfer increments the address by one.
- R9: In byte mode, `addr_out` = {page, address}. The address wraps from FFFFh to 0000h and the page stays unchanged, so a transfer never crosses a 64 KiB boundary.
- R10: In word mode, `addr_out` = {page[7:1], address, 0}, so a transfer never crosses a 128 KiB boundary.
- R11: For a cascade channel, `dack` follows the request one cycle later, every cycle. During cascade, `addr_valid` stays low and the channel's address and count are unchanged.
- R12: A pulse on `page_wr` loads `page_data` into the page register of channel `page_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register offset |
| wr_data | input | 8 | Register write byte |
| page_wr | input | 1 | Page register write strobe |
| page_ch | input | 2 | Channel for page write |
| page_data | input | 8 | Page value |
| dreq | input | 4 | Per-channel transfer requests |
| dack | output | 4 | Per-channel acknowledges |
| addr_valid | output | 1 | Bus address valid (single transfer) |
| addr_out | output | 24 | Bus address |
| mem_wr | output | 1 | High when the transfer writes memory |
| tc | output | 1 | Terminal count pulse |

## Verification
Register writes take effect at the clock edge that samples the strobe. A request takes one registered stage, so `dack`, `addr_out`, `mem_wr` and `tc` are due in the cycle after the edge that samples `dreq`. The next cycle must then be empty for single transfers. The bench drives inputs on the falling edge and reads results on the following falling edge. With this timing, every check lands in the one cycle in which the result is due. The bench also checks the gap cycle explicitly. A second instance with word addressing shares the same stimulus, and the bench compares its address form with the byte-mode instance in the same cycle.

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter bit WORD_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  wr_data,
  input  logic        page_wr,
  input  logic [1:0]  page_ch,
  input  logic [7:0]  page_data,
  input  logic [3:0]  dreq,
  output logic [3:0]  dack,
  output logic        addr_valid,
  output logic [23:0] addr_out,
  output logic        mem_wr,
  output logic        tc
);
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic [AW-1:0] cur_addr [NCH];
  logic [AW-1:0] cur_cnt  [NCH];
  logic [7:0]    page_q   [NCH];
  logic [NCH-1:0] mask_q, casc_q, memwr_q;
  logic ptr_q, hold_q;

  logic [NCH-1:0] req;
  logic [1:0] win;
  logic win_ok, grant, single;
  logic [23:0] bus_addr;
  logic [1:0] sw_ch;
  logic unused_bits;

  assign req    = dreq & ~mask_q;
  assign grant  = win_ok && !hold_q;
  assign single = grant && !casc_q[win];
  assign sw_ch  = reg_sel[2:1];
  assign unused_bits = ^wr_data[5:3];

  always_comb begin
    win = '0;
    win_ok = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (req[i]) begin
        win = 2'(i);
        win_ok = 1'b1;
      end
  end

  generate
    if (WORD_MODE) begin : g_word
      assign bus_addr = {page_q[win][7:1], cur_addr[win], 1'b0};
    end else begin : g_byte
      assign bus_addr = {page_q[win], cur_addr[win]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        cur_addr[i] <= '0;
        cur_cnt[i]  <= '0;
        page_q[i]   <= '0;
      end
      mask_q     <= '1;
      casc_q     <= '0;
      memwr_q    <= '0;
      ptr_q      <= 1'b0;
      hold_q     <= 1'b0;
      dack       <= '0;
      addr_valid <= 1'b0;
      addr_out   <= '0;
      mem_wr     <= 1'b0;
      tc         <= 1'b0;
    end else begin
      dack       <= '0;
      addr_valid <= 1'b0;
      tc         <= 1'b0;
      hold_q     <= single;
      if (grant) begin
        dack <= 4'b0001 << win;
        if (!casc_q[win]) begin
          addr_valid     <= 1'b1;
          addr_out       <= bus_addr;
          mem_wr         <= memwr_q[win];
          cur_addr[win]  <= cur_addr[win] + 1'b1;
          cur_cnt[win]   <= cur_cnt[win] - 1'b1;
          if (cur_cnt[win] == '0) begin
            tc          <= 1'b1;
            mask_q[win] <= 1'b1;
          end
        end
      end
      if (wr_en) begin
        if (!reg_sel[3]) begin
          ptr_q <= !ptr_q;
          if (!reg_sel[0]) begin
            if (ptr_q) cur_addr[sw_ch][15:8] <= wr_data;
            else       cur_addr[sw_ch][7:0]  <= wr_data;
          end else begin
            if (ptr_q) cur_cnt[sw_ch][15:8] <= wr_data;
            else       cur_cnt[sw_ch][7:0]  <= wr_data;
          end
        end else begin
          case (reg_sel)
            4'd10: mask_q[wr_data[1:0]] <= wr_data[2];
            4'd11: begin
              casc_q[wr_data[1:0]]  <= (wr_data[7:6] == 2'b11);
              memwr_q[wr_data[1:0]] <= wr_data[2];
            end
            4'd12: ptr_q <= 1'b0;
            default: ;
          endcase
        end
      end
      if (page_wr) page_q[page_ch] <= page_data;
    end
  end

  a_r7_one_dack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  a_r6_tc_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> addr_valid && (dack != 4'b0000));
  a_r8_gap_after_single: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);
  a_r5_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dack & $past(mask_q)) == 4'b0000);
  a_r11_cascade_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ((dack & $past(casc_q)) != 4'b0000) |-> !addr_valid);
endmodule

// File: tb/test_dma4_engine.sv
module test_dma4_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [7:0] wr_data = '0;
  logic page_wr = 1'b0;
  logic [1:0] page_ch = '0;
  logic [7:0] page_data = '0;
  logic [3:0] dreq = '0;
  logic [3:0] dack, w_dack;
  logic addr_valid, w_valid, mem_wr, w_mem_wr, tc, w_tc;
  logic [23:0] addr_out, w_addr;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma4_engine #(.WORD_MODE(1'b0)) i_dma4_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .page_wr(page_wr), .page_ch(page_ch), .page_data(page_data), .dreq(dreq),
    .dack(dack), .addr_valid(addr_valid), .addr_out(addr_out), .mem_wr(mem_wr), .tc(tc));

  dma4_engine #(.WORD_MODE(1'b1)) i_dma4_engine_word (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .page_wr(page_wr), .page_ch(page_ch), .page_data(page_data), .dreq(dreq),
    .dack(w_dack), .addr_valid(w_valid), .addr_out(w_addr), .mem_wr(w_mem_wr), .tc(w_tc));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_sel = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pg(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk); page_wr = 1'b1; page_ch = c; page_data = d;
    @(negedge clk); page_wr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] r);
    dreq = r;
    @(negedge clk);
  endtask

  task automatic gap(input string req);
    dreq = '0;
    @(negedge clk);
    check(req, {28'd0, dack}, 32'd0);
    check(req, {31'd0, addr_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 dack", {28'd0, dack}, 32'd0);
    check("R1 valid", {31'd0, addr_valid}, 32'd0);
    check("R1 tc", {31'd0, tc}, 32'd0);
    pulse(4'b1111);
    check("R1 masked", {28'd0, dack}, 32'd0);
    dreq = '0;
    @(negedge clk);
  endtask

  task automatic t_program_run;
    wr(4'd2, 8'hAA);
    wr(4'd12, 8'h5C);
    wr(4'd2, 8'h34); wr(4'd2, 8'h12);
    wr(4'd3, 8'h02); wr(4'd3, 8'h00);
    pg(2'd1, 8'h57);
    wr(4'd11, 8'h45);
    wr(4'd10, 8'h01);
    pulse(4'b0010);
    check("R8 dack", {28'd0, dack}, 32'h2);
    check("R8 valid", {31'd0, addr_valid}, 32'd1);
    check("R2 R3 R9 R12 addr", {8'd0, addr_out}, 32'h571234);
    check("R10 word addr", {8'd0, w_addr}, 32'h562468);
    check("R4 mem_wr", {31'd0, mem_wr}, 32'd1);
    check("R6 no early tc", {31'd0, tc}, 32'd0);
    gap("R8 gap");
    pulse(4'b0010);
    check("R8 incr", {8'd0, addr_out}, 32'h571235);
    gap("R8 gap");
    pulse(4'b0010);
    check("R6 last addr", {8'd0, addr_out}, 32'h571236);
    check("R6 tc", {31'd0, tc}, 32'd1);
    gap("R6 gap");
    pulse(4'b0010);
    check("R6 self mask", {28'd0, dack}, 32'd0);
    dreq = '0;
  endtask

  task automatic t_wrap;
    wr(4'd12, 8'h00);
    wr(4'd4, 8'hFF); wr(4'd4, 8'hFF);
    wr(4'd5, 8'h01); wr(4'd5, 8'h00);
    pg(2'd2, 8'h12);
    wr(4'd11, 8'h4A);
    wr(4'd10, 8'h02);
    pulse(4'b0100);
    check("R9 top", {8'd0, addr_out}, 32'h12FFFF);
    check("R4 mem_wr low", {31'd0, mem_wr}, 32'd0);
    gap("R9 gap");
    pulse(4'b0100);
    check("R9 wrap", {8'd0, addr_out}, 32'h120000);
    check("R6 tc wrap", {31'd0, tc}, 32'd1);
    dreq = '0;
  endtask

  task automatic t_priority;
    wr(4'd12, 8'h00);
    wr(4'd4, 8'h00); wr(4'd4, 8'h02);
    wr(4'd5, 8'h05); wr(4'd5, 8'h00);
    wr(4'd0, 8'h00); wr(4'd0, 8'h01);
    wr(4'd1, 8'h05); wr(4'd1, 8'h00);
    wr(4'd11, 8'h48);
    wr(4'd10, 8'h00);
    wr(4'd10, 8'h02);
    dreq = 4'b0101;
    @(negedge clk);
    check("R7 ch0 wins", {28'd0, dack}, 32'h1);
    check("R7 ch0 addr", {8'd0, addr_out}, 32'h000100);
    @(negedge clk);
    check("R8 held gap", {28'd0, dack}, 32'd0);
    @(negedge clk);
    check("R7 ch0 again", {28'd0, dack}, 32'h1);
    check("R8 held incr", {8'd0, addr_out}, 32'h000101);
    dreq = '0;
    wr(4'd10, 8'h04);
    pulse(4'b0101);
    check("R5 masked ch0", {28'd0, dack}, 32'h4);
    check("R7 ch2 addr", {8'd0, addr_out}, 32'h120200);
    dreq = '0;
    @(negedge clk);
  endtask

  task automatic t_cascade;
    wr(4'd12, 8'h00);
    wr(4'd6, 8'h00); wr(4'd6, 8'h03);
    wr(4'd7, 8'h00); wr(4'd7, 8'h00);
    wr(4'd11, 8'hC3);
    wr(4'd10, 8'h03);
    dreq = 4'b1000;
    @(negedge clk);
    check("R11 dack", {28'd0, dack}, 32'h8);
    check("R11 no valid", {31'd0, addr_valid}, 32'd0);
    @(negedge clk);
    check("R11 dack held", {28'd0, dack}, 32'h8);
    @(negedge clk);
    check("R11 dack held", {28'd0, dack}, 32'h8);
    dreq = '0;
    @(negedge clk);
    check("R11 release", {28'd0, dack}, 32'd0);
    wr(4'd11, 8'h4B);
    pulse(4'b1000);
    check("R11 addr unchanged", {8'd0, addr_out}, 32'h000300);
    check("R11 count unchanged", {31'd0, tc}, 32'd1);
    dreq = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program_run;
    t_wrap;
    t_priority;
    t_cascade;
    check("R10 word dack match", {28'd0, w_dack}, {28'd0, dack});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule